// File: doc/BRIEF.md
# Sequential-Write Flash Block Mapper

This block sits in a flash controller, between the host command path and the flash channel logic. It keeps one mapping entry per logical block. A logical address is cut into a logical block number and a page index within that block. Each entry holds the physical block the logical block lives in, the highest page written so far, a flag that says whether the block has been filled strictly in order, and a bit that tells a free block from one in use. Sizes are powers of two fixed by parameters, so the split is a plain bit selection.

While a block is filled page by page from page 0, every read and every next write resolves directly to a physical block and page, with no further lookup. The first write that breaks the order downgrades the block for good. After that, every read or write to it is answered with a fallback status, which a slower general-purpose translation path outside this block handles. A trim puts a block back into the free, in-order state. The first write to page 0 of a free block takes a fresh physical block id from an external free-block supplier.

Requests arrive one per cycle on a read/write lane. Trims arrive on a separate lane in the same cycle. Each request gets a registered response one cycle later.

Top module: `flash_seq_map`

## Requirements
- R1: The address is split as `lbn = addr >> (BYTE_LOG2+PAGE_LOG2)` and `page = (addr >> BYTE_LOG2) mod 2**PAGE_LOG2`. The low BYTE_LOG2 bits have no effect on the response.
- R2: After reset every logical block is free and in order, `rsp_valid` and `fb_take` are 0, and a read of any page returns fallback.
- R3: A write to page 0 of a free block pulses `fb_take` in that same cycle. It returns direct with `rsp_pblk` equal to the `fb_id` offered in that cycle and `rsp_page` = 0, and it records that id as the block's physical block.
- R4: A write to page `last+1` of an in-order block in use returns direct with the block's recorded physical block and that page, and it advances the last-written position.
- R5: Any other write to an in-order block marks the block out of order and returns fallback. This covers a rewrite of a page at or below the last position, a skip ahead, a write to a full block, and a first write at a page other than 0.
- R6: An out-of-order block stays out of order until trimmed. Every read and write to it returns fallback and leaves `fb_take` at 0.
- R7: A read of an in-order block in use returns direct for any page at or below the last-written position, in any order. It returns fallback for a higher page. A read of a free block returns fallback.
- R8: A trim returns the block to free and in order. The next write to page 0 takes a new id from the supplier.
- R9: When a trim and a write name the same block in the same cycle, the trim wins. The write is answered with status dropped, takes no id and changes nothing. A read in that cycle sees the state before the trim.
- R10: `rsp_valid` is high exactly one cycle after each cycle with `req_valid`. `rsp_status` is 0 for direct, 1 for fallback and 2 for dropped, and is never 3. `rsp_pblk` and `rsp_page` are 0 unless the status is direct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Read/write request present |
| req_wr | input | 1 | 1 = page write, 0 = page read |
| req_addr | input | ADDR_W | Logical byte address of the request |
| trim_valid | input | 1 | Trim request present |
| trim_addr | input | ADDR_W | Any byte address inside the block to trim |
| fb_id | input | 22 | Next free physical block id from the supplier |
| fb_take | output | 1 | Consumes `fb_id` at this clock edge |
| rsp_valid | output | 1 | Response present |
| rsp_status | output | 2 | 0 direct, 1 fallback, 2 dropped |
| rsp_pblk | output | 22 | Physical block on a direct response |
| rsp_page | output | PAGE_LOG2 | Page within the physical block on a direct response |

## Verification
The main function is driven with a full in-order fill of one block up to its last page, short in-order prefixes read back out of order, and each kind of order break: rewrite, skip, first write at a non-zero page, and a write past the last page. Each break separates a correct downgrade from an entry that keeps advancing. Trims alone, trims racing a write to the same block, and trims beside traffic to other blocks show whether the trim priority and the pre-trim read view hold. A long seeded random run is biased toward next-in-order pages, so blocks stay in order for a while before they break. A reference model in the bench predicts every status, location and id take.

// File: rtl/fsm_pkg.sv
package fsm_pkg;

  localparam int PBLK_W = 22;
  localparam int POS_W  = 8;

  typedef enum logic [1:0] {
    ST_DIRECT   = 2'd0,
    ST_FALLBACK = 2'd1,
    ST_DROPPED  = 2'd2
  } map_status_e;

  // 32-bit table entry: physical block, last page, in-order flag, in-use flag
  typedef struct packed {
    logic [PBLK_W-1:0] pblk;
    logic [POS_W-1:0]  pos;
    logic              in_order;
    logic              in_use;
  } map_entry_t;

  localparam map_entry_t FREE_ENTRY = '{pblk: '0, pos: '0, in_order: 1'b1, in_use: 1'b0};

endpackage

// File: rtl/fsm_addr_split.sv
module fsm_addr_split #(
  parameter int BYTE_LOG2 = 12,
  parameter int PAGE_LOG2 = 6,
  parameter int LBN_W     = 4,
  localparam int ADDR_W   = BYTE_LOG2 + PAGE_LOG2 + LBN_W
) (
  input  logic [ADDR_W-1:0]    addr,
  output logic [LBN_W-1:0]     lbn,
  output logic [PAGE_LOG2-1:0] page
);

  logic unused_byte_bits;

  assign lbn              = addr[ADDR_W-1 -: LBN_W];
  assign page             = addr[BYTE_LOG2 +: PAGE_LOG2];
  assign unused_byte_bits = ^addr[BYTE_LOG2-1:0];

endmodule

// File: rtl/fsm_entry_ctrl.sv
module fsm_entry_ctrl
  import fsm_pkg::*;
#(
  parameter int PAGE_LOG2 = 6
) (
  input  logic                 valid,
  input  logic                 is_wr,
  input  logic                 drop,
  input  logic [PAGE_LOG2-1:0] page,
  input  map_entry_t           ent,
  input  logic [PBLK_W-1:0]    fb_id,
  output map_entry_t           ent_nxt,
  output logic                 upd_en,
  output logic                 take,
  output map_status_e          status,
  output logic [PBLK_W-1:0]    loc_blk,
  output logic [PAGE_LOG2-1:0] loc_page
);

  logic [POS_W-1:0] pg_ext;
  logic [POS_W:0]   pos_inc;
  logic             next_in_line;
  logic             upd_raw;
  logic             take_raw;

  assign pg_ext       = POS_W'(page);
  assign pos_inc      = {1'b0, ent.pos} + 1'b1;
  assign next_in_line = ({1'b0, pg_ext} == pos_inc);

  always_comb begin
    ent_nxt  = ent;
    upd_raw  = 1'b0;
    take_raw = 1'b0;
    status   = ST_FALLBACK;
    loc_blk  = '0;
    loc_page = '0;
    if (drop) begin
      status = ST_DROPPED;
    end else if (is_wr) begin
      if (!ent.in_order) begin
        status = ST_FALLBACK;
      end else if (!ent.in_use) begin
        upd_raw        = 1'b1;
        ent_nxt.in_use = 1'b1;
        if (page == '0) begin
          take_raw     = 1'b1;
          ent_nxt.pblk = fb_id;
          ent_nxt.pos  = '0;
          status       = ST_DIRECT;
          loc_blk      = fb_id;
        end else begin
          ent_nxt.in_order = 1'b0;
        end
      end else if (next_in_line) begin
        upd_raw     = 1'b1;
        ent_nxt.pos = pg_ext;
        status      = ST_DIRECT;
        loc_blk     = ent.pblk;
        loc_page    = page;
      end else begin
        upd_raw          = 1'b1;
        ent_nxt.in_order = 1'b0;
      end
    end else begin
      if (ent.in_order && ent.in_use && (pg_ext <= ent.pos)) begin
        status   = ST_DIRECT;
        loc_blk  = ent.pblk;
        loc_page = page;
      end
    end
  end

  assign upd_en = valid & upd_raw;
  assign take   = valid & take_raw;

endmodule

// File: rtl/fsm_map_table.sv
module fsm_map_table
  import fsm_pkg::*;
#(
  parameter int LBN_W     = 4,
  localparam int N_BLOCKS = 1 << LBN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LBN_W-1:0] rd_idx,
  output map_entry_t       rd_ent,
  input  logic             upd_en,
  input  logic [LBN_W-1:0] upd_idx,
  input  map_entry_t       upd_ent,
  input  logic             trim_en,
  input  logic [LBN_W-1:0] trim_idx
);

  map_entry_t ent_q [N_BLOCKS];

  for (genvar i = 0; i < N_BLOCKS; i++) begin : g_ent
    logic       trim_hit;
    logic       upd_hit;
    logic       ld_en;
    map_entry_t ent_d;

    assign trim_hit = trim_en && (trim_idx == LBN_W'(i));
    assign upd_hit  = upd_en && (upd_idx == LBN_W'(i));
    assign ld_en    = trim_hit | upd_hit;

    always_comb begin
      if (trim_hit) ent_d = FREE_ENTRY;
      else          ent_d = upd_ent;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ent_q[i] <= FREE_ENTRY;
      else if (ld_en) ent_q[i] <= ent_d;
    end
  end

  assign rd_ent = ent_q[rd_idx];

endmodule

// File: rtl/flash_seq_map.sv
module flash_seq_map
  import fsm_pkg::*;
#(
  parameter int BYTE_LOG2 = 12,
  parameter int PAGE_LOG2 = 6,
  parameter int LBN_W     = 4,
  localparam int ADDR_W   = BYTE_LOG2 + PAGE_LOG2 + LBN_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_wr,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic                 trim_valid,
  input  logic [ADDR_W-1:0]    trim_addr,
  input  logic [PBLK_W-1:0]    fb_id,
  output logic                 fb_take,
  output logic                 rsp_valid,
  output logic [1:0]           rsp_status,
  output logic [PBLK_W-1:0]    rsp_pblk,
  output logic [PAGE_LOG2-1:0] rsp_page
);

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // address split for both lanes
  logic [LBN_W-1:0]     req_lbn;
  logic [PAGE_LOG2-1:0] req_page;
  logic [LBN_W-1:0]     trim_lbn;
  logic [PAGE_LOG2-1:0] unused_trim_page;

  fsm_addr_split #(.BYTE_LOG2(BYTE_LOG2), .PAGE_LOG2(PAGE_LOG2), .LBN_W(LBN_W)) u_req_split (
    .addr (req_addr),
    .lbn  (req_lbn),
    .page (req_page)
  );

  fsm_addr_split #(.BYTE_LOG2(BYTE_LOG2), .PAGE_LOG2(PAGE_LOG2), .LBN_W(LBN_W)) u_trim_split (
    .addr (trim_addr),
    .lbn  (trim_lbn),
    .page (unused_trim_page)
  );

  // table and per-request decision
  map_entry_t           cur_ent;
  map_entry_t           nxt_ent;
  logic                 upd_en;
  logic                 take;
  logic                 wr_dropped;
  map_status_e          dec_status;
  logic [PBLK_W-1:0]    dec_blk;
  logic [PAGE_LOG2-1:0] dec_page;

  assign wr_dropped = trim_valid && req_wr && (trim_lbn == req_lbn);

  fsm_map_table #(.LBN_W(LBN_W)) u_table (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rd_idx   (req_lbn),
    .rd_ent   (cur_ent),
    .upd_en   (upd_en),
    .upd_idx  (req_lbn),
    .upd_ent  (nxt_ent),
    .trim_en  (trim_valid),
    .trim_idx (trim_lbn)
  );

  fsm_entry_ctrl #(.PAGE_LOG2(PAGE_LOG2)) u_ctrl (
    .valid    (req_valid),
    .is_wr    (req_wr),
    .drop     (wr_dropped),
    .page     (req_page),
    .ent      (cur_ent),
    .fb_id    (fb_id),
    .ent_nxt  (nxt_ent),
    .upd_en   (upd_en),
    .take     (take),
    .status   (dec_status),
    .loc_blk  (dec_blk),
    .loc_page (dec_page)
  );

  assign fb_take = take;

  // response register: next-state and register processes
  logic                 vld_d, vld_q;
  map_status_e          st_d, st_q;
  logic [PBLK_W-1:0]    blk_d, blk_q;
  logic [PAGE_LOG2-1:0] pg_d, pg_q;
  logic                 pay_en;

  always_comb begin
    vld_d  = req_valid;
    pay_en = req_valid;
    st_d   = dec_status;
    blk_d  = dec_blk;
    pg_d   = dec_page;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) vld_q <= 1'b0;
    else             vld_q <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q  <= ST_FALLBACK;
      blk_q <= '0;
      pg_q  <= '0;
    end else if (pay_en) begin
      st_q  <= st_d;
      blk_q <= blk_d;
      pg_q  <= pg_d;
    end
  end

  assign rsp_valid  = vld_q;
  assign rsp_status = st_q;
  assign rsp_pblk   = blk_q;
  assign rsp_page   = pg_q;

endmodule

// File: rtl/fsm_checker.sv
module fsm_checker
  import fsm_pkg::*;
#(
  parameter int BYTE_LOG2 = 12,
  parameter int PAGE_LOG2 = 6,
  parameter int LBN_W     = 4,
  localparam int ADDR_W   = BYTE_LOG2 + PAGE_LOG2 + LBN_W
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_wr,
  input logic [ADDR_W-1:0]    req_addr,
  input logic                 trim_valid,
  input logic [ADDR_W-1:0]    trim_addr,
  input logic [PBLK_W-1:0]    fb_id,
  input logic                 fb_take,
  input logic                 rsp_valid,
  input logic [1:0]           rsp_status,
  input logic [PBLK_W-1:0]    rsp_pblk,
  input logic [PAGE_LOG2-1:0] rsp_page
);

  logic same_blk;
  logic unused_chk;

  assign same_blk   = (req_addr[ADDR_W-1 -: LBN_W] == trim_addr[ADDR_W-1 -: LBN_W]);
  assign unused_chk = ^{req_addr[ADDR_W-LBN_W-1:0], trim_addr[ADDR_W-LBN_W-1:0]};

  a_r10_rsp_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  a_r10_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  a_r10_legal_status: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_status != 2'd3);

  a_r10_loc_zero_unless_direct: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status != ST_DIRECT) |-> (rsp_pblk == '0 && rsp_page == '0));

  a_r3_take_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    fb_take |-> (req_valid && req_wr));

  a_r3_take_gives_fresh_id: assert property (@(posedge clk) disable iff (!rst_n)
    fb_take |=> (rsp_valid && rsp_status == ST_DIRECT && rsp_page == '0 && rsp_pblk == $past(fb_id)));

  a_r9_trim_blocks_take: assert property (@(posedge clk) disable iff (!rst_n)
    (trim_valid && req_valid && req_wr && same_blk) |-> !fb_take);

  a_r9_trim_drops_write: assert property (@(posedge clk) disable iff (!rst_n)
    (trim_valid && req_valid && req_wr && same_blk) |=> (rsp_valid && rsp_status == ST_DROPPED));

endmodule

bind flash_seq_map fsm_checker #(
  .BYTE_LOG2 (BYTE_LOG2),
  .PAGE_LOG2 (PAGE_LOG2),
  .LBN_W     (LBN_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .req_valid  (req_valid),
  .req_wr     (req_wr),
  .req_addr   (req_addr),
  .trim_valid (trim_valid),
  .trim_addr  (trim_addr),
  .fb_id      (fb_id),
  .fb_take    (fb_take),
  .rsp_valid  (rsp_valid),
  .rsp_status (rsp_status),
  .rsp_pblk   (rsp_pblk),
  .rsp_page   (rsp_page)
);

// File: tb/sim_flash_seq_map.sv
`timescale 1ns/1ps
module sim_flash_seq_map;

  localparam int BL    = 12;
  localparam int PL    = 6;
  localparam int LW    = 4;
  localparam int AW    = BL + PL + LW;
  localparam int NBLK  = 1 << LW;
  localparam int NPG   = 1 << PL;
  localparam int BASE  = 'h1000;
  localparam int S_DIR = 0;
  localparam int S_FB  = 1;
  localparam int S_DRP = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_wr, trim_valid;
  logic [AW-1:0] req_addr, trim_addr;
  logic [21:0]   fb_id;
  logic          fb_take;
  logic          rsp_valid;
  logic [1:0]    rsp_status;
  logic [21:0]   rsp_pblk;
  logic [PL-1:0] rsp_page;

  int checks = 0;
  int errors = 0;
  int stub_ctr = 0;
  bit done = 0;

  // reference model state
  bit m_use [NBLK];
  bit m_ord [NBLK];
  int m_pos [NBLK];
  int m_blk [NBLK];
  int m_alloc = 0;

  always #5 clk = ~clk;

  assign fb_id = 22'(BASE + stub_ctr);
  always @(posedge clk) if (fb_take) stub_ctr <= stub_ctr + 1;

  flash_seq_map #(.BYTE_LOG2(BL), .PAGE_LOG2(PL), .LBN_W(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_wr(req_wr), .req_addr(req_addr),
    .trim_valid(trim_valid), .trim_addr(trim_addr), .fb_id(fb_id), .fb_take(fb_take),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_pblk(rsp_pblk), .rsp_page(rsp_page)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mk_addr(input int lbn, input int pg, input int off);
    return AW'((lbn << (PL + BL)) | ((pg % NPG) << BL) | (off % (1 << BL)));
  endfunction

  // one request cycle: drive at a falling edge, check response at the next one
  task automatic step(input bit rv, input bit wr, input int lbn, input int pg,
                      input bit tv, input int tl, input string tag_in);
    int st = S_FB; int eb = 0; int ep = 0; bit et = 0;
    string tag = tag_in;
    req_valid  = rv;
    req_wr     = wr;
    req_addr   = mk_addr(lbn, pg, int'($urandom % (1 << BL)));
    trim_valid = tv;
    trim_addr  = mk_addr(tl, int'($urandom % NPG), int'($urandom % (1 << BL)));
    if (rv) begin
      if (wr) begin
        if (tv && tl == lbn) st = S_DRP;
        else if (!m_ord[lbn]) st = S_FB;
        else if (!m_use[lbn]) begin
          m_use[lbn] = 1;
          if (pg == 0) begin
            et = 1; st = S_DIR; eb = BASE + m_alloc; m_alloc++;
            m_blk[lbn] = eb; m_pos[lbn] = 0;
          end else m_ord[lbn] = 0;
        end else if (pg == m_pos[lbn] + 1) begin
          m_pos[lbn] = pg; st = S_DIR; eb = m_blk[lbn]; ep = pg;
        end else m_ord[lbn] = 0;
      end else if (m_ord[lbn] && m_use[lbn] && pg <= m_pos[lbn]) begin
        st = S_DIR; eb = m_blk[lbn]; ep = pg;
      end
    end
    if (tv) begin m_use[tl] = 0; m_ord[tl] = 1; m_pos[tl] = 0; end
    if (tag == "") begin
      if (!wr) tag = "R7";
      else if (st == S_DRP) tag = "R9";
      else if (st == S_DIR) tag = (pg == 0) ? "R3" : "R4";
      else tag = "R5";
    end
    #1;
    chk(tag, "fb_take", int'(fb_take), int'(et));
    @(negedge clk);
    chk("R10", "rsp_valid", int'(rsp_valid), int'(rv));
    if (rv) begin
      chk(tag, "status", int'(rsp_status), st);
      chk(tag, "pblk", int'(rsp_pblk), eb);
      chk(tag, "page", int'(rsp_page), ep);
    end
  endtask

  task automatic idle();
    req_valid = 0; req_wr = 0; trim_valid = 0;
    @(negedge clk);
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < NBLK; i++) begin
      m_use[i] = 0; m_ord[i] = 1; m_pos[i] = 0; m_blk[i] = 0;
    end
    rst_n = 0; req_valid = 0; req_wr = 0; trim_valid = 0;
    req_addr = '0; trim_addr = '0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R2: reset state
    chk("R2", "rsp_valid after reset", int'(rsp_valid), 0);
    chk("R2", "fb_take after reset", int'(fb_take), 0);
    step(1, 0, 3, 0, 0, 0, "R2");

    // R3 / R4 / R1: fill block 1 completely, random byte offsets each time
    step(1, 1, 1, 0, 0, 0, "R3");
    for (int p = 1; p < NPG; p++) step(1, 1, 1, p, 0, 0, "R1");
    step(1, 0, 1, NPG - 1, 0, 0, "R7");
    step(1, 1, 1, 0, 0, 0, "R5");          // write past a full block
    step(1, 0, 1, 5, 0, 0, "R6");

    // R7: short prefix on block 2, read back out of order
    for (int p = 0; p < 5; p++) step(1, 1, 2, p, 0, 0, "R4");
    step(1, 0, 2, 3, 0, 0, "R7");
    step(1, 0, 2, 0, 0, 0, "R7");
    step(1, 0, 2, 4, 0, 0, "R7");
    step(1, 0, 2, 5, 0, 0, "R7");
    step(1, 0, 7, 0, 0, 0, "R7");          // free block read

    // R5 / R6: rewrite breaks the order, then everything falls back
    step(1, 1, 2, 2, 0, 0, "R5");
    step(1, 0, 2, 0, 0, 0, "R6");
    step(1, 1, 2, 5, 0, 0, "R6");
    step(1, 1, 2, 0, 0, 0, "R6");

    // R5: skip ahead and non-zero first write
    step(1, 1, 5, 0, 0, 0, "R3");
    step(1, 1, 5, 2, 0, 0, "R5");
    step(1, 1, 6, 3, 0, 0, "R5");
    step(1, 1, 6, 0, 0, 0, "R6");

    // R8: trim alone, then a fresh allocation
    step(0, 0, 0, 0, 1, 2, "R8");
    step(1, 0, 2, 0, 0, 0, "R8");
    step(1, 1, 2, 0, 0, 0, "R8");
    step(1, 1, 2, 1, 0, 0, "R8");

    // R9: trim racing a write on the same block, and a read on the trimmed block
    for (int p = 0; p < 3; p++) step(1, 1, 4, p, 0, 0, "R4");
    step(1, 1, 4, 3, 1, 4, "R9");
    step(1, 0, 4, 0, 0, 0, "R9");
    step(1, 1, 8, 0, 0, 0, "R3");
    step(1, 0, 8, 0, 1, 8, "R9");          // read sees pre-trim state
    step(1, 0, 8, 0, 0, 0, "R9");
    step(1, 1, 9, 0, 1, 10, "R9");         // different blocks: both act
    step(1, 1, 4, 0, 0, 0, "R8");

    // random phase, biased toward the next in-order page
    for (int n = 0; n < 3000; n++) begin
      int lbn = int'($urandom % NBLK);
      int pg;
      bit wr  = ($urandom % 2) == 1;
      bit tv  = ($urandom % 10) == 0;
      int tl  = ($urandom % 3 == 0) ? lbn : int'($urandom % NBLK);
      bit rv  = ($urandom % 8) != 0;
      if ($urandom % 10 < 6) pg = m_use[lbn] ? (m_pos[lbn] + 1) % NPG : 0;
      else pg = int'($urandom % 8);
      step(rv, wr, lbn, pg, tv, tl, "");
    end

    idle();
    chk("R10", "rsp_valid idle", int'(rsp_valid), 0);
    done = 1;
    report();
  end

endmodule